// File: doc/BRIEF.md
# Target-Time Pulse Output

This block turns a free-running, scaled system time into a pulse output whose edges fall on exact time boundaries. Software programs an absolute 64-bit target time and a 64-bit period through a simple word-wide write port. It then sets the control bits. While the generator runs, the target is compared against the system time on every clock. When the time reaches the target, the output level flips and the target advances by one period. This re-arms the compare with no software involved.

Set the period to one second in scaled units and pick a start target on a second boundary, and the output becomes a second-aligned pulse train. Software computes that start target. An optional interrupt pulse marks each change of the pin level. A pad-configuration register holds two bits: one makes the pin an output, and one connects it to the time compare. Both must be set before the pin is driven.

Top module: `tgt_pulse_gen`

## Requirements
- R1: After a synchronous active-low reset, `pin_out`, `pin_oe` and `irq_pulse` are 0, and the control, pad, target and period registers are all 0.
- R2: A write with `wr_en` high takes effect at the same clock edge. The address map is:
  - 0: control. Bit 0 is enable, bit 1 is time-sync and bit 2 is interrupt-on-edge.
  - 1: pad. Bit 0 is output direction and bit 1 is route-to-time-compare.
  - 2 and 3: target, low and high words.
  - 4 and 5: period, low and high words.
- R3: The generator runs when enable, time-sync, output direction and route are all 1. At a clock edge where it runs and `sys_time` >= target, `pin_out` inverts and the target becomes target + period, modulo 2^64.
- R4: A system time exactly equal to the target counts as reached. A time one below the target does not.
- R5: At most one toggle happens per clock. When the target lies well in the past, the pin toggles on consecutive clocks, each toggle advancing the target by one period, until the target passes the time.
- R6: `irq_pulse` is high for the single clock after each toggle, and only if interrupt-on-edge is set. With that bit clear, toggles raise no interrupt.
- R7: While the generator does not run, `pin_out` is held low, no interrupt is raised and the target does not move. This covers a control value of 0 and enable without time-sync. Writing 0 to control drives the pin low at the next edge.
- R8: Writes to the target or period words are ignored while the enable bit is 1.
- R9: `pin_oe` equals the pad output-direction bit. With direction set but route clear, the pin stays low even when enabled and past the target.
- R10: The time compare is unsigned over all 64 bits. A time with bit 63 set is past a small target. A low word of all ones with a high word of 0 is still below a target of 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_time | input | 64 | Running scaled system time |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address |
| wr_data | input | 32 | Register write data |
| pin_out | output | 1 | Pulse output level |
| pin_oe | output | 1 | Output enable for the pin pad |
| irq_pulse | output | 1 | One-clock pulse on each pin change |

## Verification
The compare is tried with a time that approaches the target from below, then hits it exactly, then passes it. This separates a `>=` compare from a `>` compare, and it shows the period being added at each hit.

A time far beyond the target tells one-toggle-per-clock re-arming apart from a jump straight to the current time. A time just below 2^32 against a target of 2^32 catches a compare that ignores the high word. A time with bit 63 set catches a signed compare.

A target near the top of the range checks that the target wraps modulo 2^64. Further runs cover three cases where the pin must stay low: a write to the target while enabled, enable without time-sync, and route cleared. Each of these could otherwise toggle the pin.

// File: rtl/tpg_pkg.sv
// Shared types and fixed register addresses for the target-time pulse generator.
package tpg_pkg;
    localparam int CTL_W     = 3;
    localparam int PAD_W     = 2;
    localparam int ADDR_CTL  = 0;
    localparam int ADDR_PAD  = 1;
    localparam int ADDR_TGT0 = 2;   // target words follow, then period words

    typedef struct packed {
        logic irq_on_edge;
        logic time_sync;
        logic enable;
    } tpg_ctl_t;

    typedef struct packed {
        logic route_ts;
        logic dir_out;
    } tpg_pad_t;
endpackage

// File: rtl/tpg_regs.sv
// Register file: control, pad configuration and period words, plus
// write strobes for the target words (the target itself lives in tpg_arm).
// Assumes TW is a multiple of DW. Target/period writes are locked while enabled.
module tpg_regs
    import tpg_pkg::*;
#(
    parameter int TW = 64,
    parameter int DW = 32,
    parameter int AW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    output tpg_ctl_t         ctl,
    output tpg_pad_t         pad,
    output logic [TW-1:0]    period,
    output logic [TW/DW-1:0] tgt_we,
    output logic             run
);
    localparam int NW   = TW / DW;
    localparam int PER0 = ADDR_TGT0 + NW;

    // Control and pad registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
            pad <= '0;
        end else if (wr_en) begin
            if (wr_addr == AW'(ADDR_CTL)) ctl <= tpg_ctl_t'(wr_data[CTL_W-1:0]);
            if (wr_addr == AW'(ADDR_PAD)) pad <= tpg_pad_t'(wr_data[PAD_W-1:0]);
        end
    end

    // Period words, writable only while the enable bit is clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period <= '0;
        end else if (wr_en && !ctl.enable) begin
            for (int w = 0; w < NW; w++)
                if (wr_addr == AW'(PER0 + w)) period[w*DW +: DW] <= wr_data;
        end
    end

    // Target-word write strobes, with the same enable lock.
    always_comb begin
        for (int w = 0; w < NW; w++)
            tgt_we[w] = wr_en && !ctl.enable && (wr_addr == AW'(ADDR_TGT0 + w));
    end

    // Running only when fully configured.
    assign run = ctl.enable && ctl.time_sync && pad.dir_out && pad.route_ts;

    AST_PERIOD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.enable |=> $stable(period));   // R8
endmodule

// File: rtl/tpg_arm.sv
// Target register with compare and automatic re-arm.
// Assumes fire and a target word write never coincide (writes are locked when enabled).
module tpg_arm #(
    parameter int TW = 64,
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TW-1:0]    sys_time,
    input  logic [TW-1:0]    period,
    input  logic [TW/DW-1:0] tgt_we,
    input  logic [DW-1:0]    tgt_wdata,
    output logic             fire
);
    localparam int NW = TW / DW;

    logic [TW-1:0] target;

    // Unsigned reach test, once per clock.
    assign fire = run && (sys_time >= target);

    // Advance by one period on a hit, otherwise accept word writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target <= '0;
        end else if (fire) begin
            target <= target + period;
        end else begin
            for (int w = 0; w < NW; w++)
                if (tgt_we[w]) target[w*DW +: DW] <= tgt_wdata;
        end
    end

    AST_TGT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> ((target - $past(target)) == $past(period)));   // R3

    AST_TGT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && (tgt_we == '0)) |=> $stable(target));   // R7
endmodule

// File: rtl/tpg_pin.sv
// Output level and edge interrupt. The pin is forced low whenever not running.
module tpg_pin (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fire,
    input  logic irq_en,
    output logic pin_q,
    output logic irq_q
);
    // Toggle on each hit, clear when idle, flag the change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= fire && irq_en;
            if (!run)       pin_q <= 1'b0;
            else if (fire)  pin_q <= ~pin_q;
        end
    end

    AST_IRQ_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (pin_q != $past(pin_q)));   // R6

    AST_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!pin_q && !irq_q));   // R7
endmodule

// File: rtl/tgt_pulse_gen.sv
// Top: target-time periodic clock output. Compares absolute scaled time
// against a programmed target, toggles the pin and re-arms by a period.
// Assumes sys_time is synchronous to clk.
module tgt_pulse_gen
    import tpg_pkg::*;
#(
    parameter int TW = 64,
    parameter int DW = 32,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] sys_time,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          pin_out,
    output logic          pin_oe,
    output logic          irq_pulse
);
    localparam int NW = TW / DW;

    tpg_ctl_t      ctl;
    tpg_pad_t      pad;
    logic [TW-1:0] period;
    logic [NW-1:0] tgt_we;
    logic          run;
    logic          fire;

    tpg_regs #(.TW(TW), .DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctl(ctl), .pad(pad), .period(period),
        .tgt_we(tgt_we), .run(run)
    );

    tpg_arm #(.TW(TW), .DW(DW)) u_arm (
        .clk(clk), .rst_n(rst_n), .run(run), .sys_time(sys_time),
        .period(period), .tgt_we(tgt_we), .tgt_wdata(wr_data), .fire(fire)
    );

    tpg_pin u_pin (
        .clk(clk), .rst_n(rst_n), .run(run), .fire(fire),
        .irq_en(ctl.irq_on_edge), .pin_q(pin_out), .irq_q(irq_pulse)
    );

    // Pad driver enable follows the direction bit.
    assign pin_oe = pad.dir_out;
endmodule

// File: tb/tgt_pulse_gen_bench.sv
`timescale 1ns/1ps
module tgt_pulse_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] sys_time = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        pin_out, pin_oe, irq_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Scoreboard queues: expected {pin, irq, oe} and requirement tag.
    logic [2:0] exp_q[$];
    string      tag_q[$];

    // Reference state kept from the requirements.
    logic [2:0]  m_ctl = '0;
    logic [1:0]  m_pad = '0;
    logic [63:0] m_tgt = '0;
    logic [63:0] m_per = '0;
    logic        m_pin = 1'b0;

    always #2.5 clk = ~clk;

    tgt_pulse_gen u_tgt_pulse_gen (
        .clk(clk), .rst_n(rst_n), .sys_time(sys_time), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq_pulse(irq_pulse)
    );

    // Driver: apply one cycle of stimulus and push the expected outcome.
    task automatic drive(input logic we, input logic [2:0] a, input logic [31:0] d,
                         input logic [63:0] t, input string tag);
        logic run, fire, irq;
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; sys_time = t;
        run  = m_ctl[0] && m_ctl[1] && m_pad[0] && m_pad[1];
        fire = run && (t >= m_tgt);
        irq  = fire && m_ctl[2];
        if (!run)      m_pin = 1'b0;
        else if (fire) m_pin = ~m_pin;
        if (fire) m_tgt = m_tgt + m_per;
        if (we) begin
            case (a)
                3'd0: m_ctl = d[2:0];
                3'd1: m_pad = d[1:0];
                3'd2: if (!m_ctl[0]) m_tgt[31:0]  = d;
                3'd3: if (!m_ctl[0]) m_tgt[63:32] = d;
                3'd4: if (!m_ctl[0]) m_per[31:0]  = d;
                3'd5: if (!m_ctl[0]) m_per[63:32] = d;
                default: ;
            endcase
        end
        exp_q.push_back({m_pin, irq, m_pad[0]});
        tag_q.push_back(tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [63:0] t,
                      input string tag);
        drive(1'b1, a, d, t, tag);
    endtask

    task automatic tick(input logic [63:0] t, input string tag);
        drive(1'b0, 3'd0, 32'd0, t, tag);
    endtask

    // Monitor: compare outputs just after each edge against the queue.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [2:0] e;
            string tg;
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            checks++;
            if ({pin_out, irq_pulse, pin_oe} !== e) begin
                errors++;
                $display("FAIL %s pin/irq/oe got %b expected %b", tg,
                         {pin_out, irq_pulse, pin_oe}, e);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if ({pin_out, irq_pulse, pin_oe} !== 3'b000) begin
            errors++;
            $display("FAIL R1 reset pin/irq/oe got %b expected 000",
                     {pin_out, irq_pulse, pin_oe});
        end
        // R2: program pad, target 100, period 50, then run with interrupts.
        wr(3'd1, 32'd3, 64'd0, "R2");
        wr(3'd2, 32'd100, 64'd0, "R2");
        wr(3'd3, 32'd0, 64'd0, "R2");
        wr(3'd4, 32'd50, 64'd0, "R2");
        wr(3'd5, 32'd0, 64'd0, "R2");
        wr(3'd0, 32'd7, 64'd0, "R2");
        tick(64'd90, "R3");
        tick(64'd99, "R4");
        tick(64'd100, "R4");
        tick(64'd100, "R5");
        tick(64'd150, "R3");
        // R8: target write while enabled is ignored.
        wr(3'd2, 32'd5, 64'd160, "R8");
        tick(64'd199, "R8");
        tick(64'd200, "R8");
        // R5: far past target, one toggle per clock.
        for (int i = 0; i < 5; i++) tick(64'd1000, "R5");
        // R6: interrupts off, toggles continue silently.
        wr(3'd0, 32'd3, 64'd0, "R6");
        tick(64'd1000, "R6");
        tick(64'd1000, "R6");
        // R7: disable drives the pin low, no further activity.
        wr(3'd0, 32'd0, 64'd1000, "R7");
        tick(64'd1000, "R7");
        tick(64'd5000, "R7");
        wr(3'd0, 32'd5, 64'd5000, "R7");
        tick(64'd5000, "R7");
        tick(64'd5000, "R7");
        // R9: direction without route keeps pin low; oe follows direction.
        wr(3'd0, 32'd0, 64'd0, "R9");
        wr(3'd1, 32'd1, 64'd0, "R9");
        wr(3'd0, 32'd7, 64'd0, "R9");
        tick(64'd9000, "R9");
        tick(64'd9000, "R9");
        wr(3'd0, 32'd0, 64'd0, "R9");
        wr(3'd1, 32'd0, 64'd0, "R9");
        wr(3'd1, 32'd3, 64'd0, "R9");
        // R10: unsigned compare across words, target 2^32, period 1.
        wr(3'd2, 32'd0, 64'd0, "R10");
        wr(3'd3, 32'd1, 64'd0, "R10");
        wr(3'd4, 32'd1, 64'd0, "R10");
        wr(3'd5, 32'd0, 64'd0, "R10");
        wr(3'd0, 32'd7, 64'd0, "R10");
        tick(64'h0000_0000_FFFF_FFFF, "R10");
        tick(64'h8000_0000_0000_0000, "R10");
        tick(64'h0000_0000_FFFF_FFFF, "R10");
        // R3: target wraps modulo 2^64.
        wr(3'd0, 32'd0, 64'd0, "R3");
        wr(3'd2, 32'hFFFF_FFF0, 64'd0, "R3");
        wr(3'd3, 32'hFFFF_FFFF, 64'd0, "R3");
        wr(3'd4, 32'h20, 64'd0, "R3");
        wr(3'd0, 32'd7, 64'd0, "R3");
        tick(64'hFFFF_FFFF_FFFF_FFFF, "R3");
        tick(64'h0F, "R3");
        tick(64'h10, "R3");
        tick(64'h10, "R3");
        @(negedge clk) wr_en = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule